// File: doc/BRIEF.md
# Byte-Window Multiply/Divide Unit

This block is an unsigned arithmetic engine reached through a small byte-wide register window. Software loads operands one byte at a time, and one write starts the work. A write to the high byte of the multiplier starts a 16×16 multiply. A write to the high byte of the divisor starts a 32÷16 divide. No command field selects the operation.

Both operations share the same registers. A four-byte operand area holds the 32-bit dividend, and its low half is also the multiplicand. A four-byte result area holds either the product or the quotient. A two-byte area holds the remainder. A status byte shows a busy flag while the engine runs. A write to a dedicated clear address zeroes the whole window. The multiply handles one multiplier bit per clock. The divide is a restoring divider that produces one quotient bit per clock.

Top module: `muldiv_window`

## Requirements
- R1: After reset, every readable byte at addresses 0 to 13 and the status byte at address 15 read as zero. Multi-byte fields are little-endian: operand A at 0..3, multiplier at 4..5, divisor at 6..7, result at 8..11, remainder at 12..13.
- R2: A write to address 5 starts a multiply of operand A bits 15:0 by the 16-bit multiplier, using the newly written high byte. Bytes 2..3 of operand A play no part in it. The unsigned 32-bit product appears at addresses 8..11, and the remainder bytes keep their previous value.
- R3: A write to address 7 starts a divide of the 32-bit operand A by the 16-bit divisor, using the newly written high byte. The unsigned quotient appears at 8..11 and the remainder at 12..13.
- R4: Status bit 7 (address 15) reads 1 from the clock edge that takes a start write until the operation finishes, and 0 otherwise. Status bits 6:0 always read 0.
- R5: A multiply holds busy for exactly 16 clock cycles after its start edge. A divide holds busy for exactly 32.
- R6: When the divisor is zero, the quotient is 0xFFFFFFFF and the remainder equals the low 16 bits of the dividend.
- R7: A start write while busy abandons the running operation and starts the new one, with a full new busy period. Only the new result is stored.
- R8: A write of any value to address 14 zeroes all operand, result and remainder bytes and ends any running operation, so busy reads 0.
- R9: Operand writes made while an operation runs do not change its result. Writes to the result, remainder or status addresses are ignored.
- R10: The result and remainder bytes change only when an operation finishes or a clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 4 | Register window byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
The multiply is tried with these input patterns:
- Mixed values, which exercise the carries.
- Both operands at their maximum, which tests the top carry.
- A zero operand and a unit operand, which expose shift and alignment errors.
- Nonzero upper operand bytes, which show that the multiplicand width is respected.

The divide is tried with these input patterns:
- A large dividend with a mid-size divisor, where every quotient bit matters.
- A divisor of one, which tests the full-width shift.
- A dividend smaller than the divisor, which must give a zero quotient and pass the dividend through as the remainder.
- A zero divisor, which must give the saturated quotient.

Busy-length counting separates the two operation lengths. The restart, clear and write-during-run scenarios show that the working state is held apart from the visible window.

// File: rtl/muldiv_window.sv
module muldiv_window (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int MUL_STEPS = 16;
  localparam int DIV_STEPS = 32;
  localparam logic [3:0] A_MHI = 4'd5, A_DHI = 4'd7, A_CLR = 4'd14, A_STAT = 4'd15;

  logic [31:0] opa, res, acc;
  logic [15:0] mlt, dvs, rmd, part, opnd;
  logic        busy, is_div;
  logic [5:0]  cnt;

  wire start_mul = wr && addr == A_MHI;
  wire start_div = wr && addr == A_DHI;
  wire clr       = wr && addr == A_CLR;

  wire [16:0] mul_sum  = {1'b0, acc[31:16]} + (acc[0] ? {1'b0, opnd} : 17'd0);
  wire [31:0] mul_next = {mul_sum, acc[15:1]};
  wire [16:0] dv_t     = {part, acc[31]};
  wire        dv_ge    = dv_t >= {1'b0, opnd};
  wire [16:0] dv_sub   = dv_t - {1'b0, opnd};
  wire [15:0] part_nx  = dv_ge ? dv_sub[15:0] : dv_t[15:0];
  wire [31:0] div_next = {acc[30:0], dv_ge};
  wire        last     = cnt == (is_div ? 6'(DIV_STEPS - 1) : 6'(MUL_STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa <= '0; mlt <= '0; dvs <= '0; res <= '0; rmd <= '0;
      acc <= '0; part <= '0; opnd <= '0; busy <= 1'b0; is_div <= 1'b0; cnt <= '0;
    end else begin
      if (busy) begin
        cnt <= cnt + 6'd1;
        if (is_div) begin
          acc  <= div_next;
          part <= part_nx;
        end else begin
          acc  <= mul_next;
        end
        if (last) begin
          busy <= 1'b0;
          res  <= is_div ? div_next : mul_next;
          if (is_div) rmd <= part_nx;
        end
      end
      if (wr) begin
        case (addr)
          4'd0: opa[7:0]   <= wdata;
          4'd1: opa[15:8]  <= wdata;
          4'd2: opa[23:16] <= wdata;
          4'd3: opa[31:24] <= wdata;
          4'd4: mlt[7:0]   <= wdata;
          4'd5: mlt[15:8]  <= wdata;
          4'd6: dvs[7:0]   <= wdata;
          4'd7: dvs[15:8]  <= wdata;
          default: ;
        endcase
      end
      if (start_mul) begin
        busy <= 1'b1; is_div <= 1'b0; cnt <= '0;
        acc  <= {16'h0, wdata, mlt[7:0]};
        opnd <= opa[15:0];
      end else if (start_div) begin
        busy <= 1'b1; is_div <= 1'b1; cnt <= '0;
        acc  <= opa;
        part <= '0;
        opnd <= {wdata, dvs[7:0]};
      end else if (clr) begin
        opa <= '0; mlt <= '0; dvs <= '0; res <= '0; rmd <= '0; busy <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:  rdata = opa[7:0];
      4'd1:  rdata = opa[15:8];
      4'd2:  rdata = opa[23:16];
      4'd3:  rdata = opa[31:24];
      4'd4:  rdata = mlt[7:0];
      4'd5:  rdata = mlt[15:8];
      4'd6:  rdata = dvs[7:0];
      4'd7:  rdata = dvs[15:8];
      4'd8:  rdata = res[7:0];
      4'd9:  rdata = res[15:8];
      4'd10: rdata = res[23:16];
      4'd11: rdata = res[31:24];
      4'd12: rdata = rmd[7:0];
      4'd13: rdata = rmd[15:8];
      A_STAT: rdata = {busy, 7'd0};
      default: rdata = 8'd0;
    endcase
  end

  a_r4_mul_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_mul |=> busy);
  a_r4_div_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_div |=> busy);
  a_r4_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_STAT |-> rdata[6:0] == 7'd0);
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (res == 32'd0 && rmd == 16'd0 && opa == 32'd0 && mlt == 16'd0 && dvs == 16'd0 && !busy));
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> ($stable(res) && $stable(rmd)));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < 6'(DIV_STEPS));
endmodule

// File: tb/muldiv_window_test.sv
module muldiv_window_test;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  muldiv_window uut (.clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wbyte(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 4'd15;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic rd32(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(a + 4'(i), b); v[8*i +: 8] = b; end
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] b;
    rd(a, b); v[7:0] = b; rd(a + 4'd1, b); v[15:8] = b;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    rd(4'd15, s);
    while (s[7] && n < 100) begin n++; @(negedge clk); rd(4'd15, s); end
  endtask

  task automatic load_a(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wbyte(4'(i), v[8*i +: 8]);
  endtask

  task automatic do_mul(input logic [31:0] a, input logic [15:0] b, input string req);
    int n; logic [31:0] r; logic [15:0] rm0, rm1;
    rd16(4'd12, rm0);
    load_a(a); wbyte(4'd4, b[7:0]); wbyte(4'd5, b[15:8]);
    wait_idle(n);
    chk({req, " R5 mul busy cycles"}, n, 16);
    rd32(4'd8, r); chk({req, " R2 product"}, r, a[15:0] * b);
    rd16(4'd12, rm1); chk({req, " R2 remainder kept"}, rm1, rm0);
  endtask

  task automatic do_div(input logic [31:0] a, input logic [15:0] d, input string req);
    int n; logic [31:0] q; logic [15:0] rm;
    load_a(a); wbyte(4'd6, d[7:0]); wbyte(4'd7, d[15:8]);
    wait_idle(n);
    chk({req, " R5 div busy cycles"}, n, 32);
    rd32(4'd8, q); rd16(4'd12, rm);
    if (d == 0) begin
      chk({req, " R6 quotient"}, q, 32'hFFFF_FFFF);
      chk({req, " R6 remainder"}, rm, a[15:0]);
    end else begin
      chk({req, " R3 quotient"}, q, a / d);
      chk({req, " R3 remainder"}, rm, a % d);
    end
  endtask

  task automatic t_reset;
    logic [7:0] b;
    for (int i = 0; i < 14; i++) begin rd(4'(i), b); chk("R1 reset byte", b, 0); end
    rd(4'd15, b); chk("R1 reset status", b, 0);
  endtask

  task automatic t_status;
    logic [7:0] s; int n;
    load_a(32'h0000_0003); wbyte(4'd4, 8'h05); wbyte(4'd5, 8'h00);
    rd(4'd15, s); chk("R4 status busy value", s, 8'h80);
    wait_idle(n);
    rd(4'd15, s); chk("R4 status idle value", s, 8'h00);
  endtask

  task automatic t_restart;
    int n; logic [31:0] r;
    load_a(32'h1000_0042); wbyte(4'd6, 8'h03); wbyte(4'd7, 8'h00);
    repeat (5) @(negedge clk);
    wbyte(4'd4, 8'h10); wbyte(4'd5, 8'h00);
    wait_idle(n);
    chk("R7 restart busy cycles", n, 16);
    rd32(4'd8, r); chk("R7 restart product", r, 32'h0000_0420);
  endtask

  task automatic t_clear;
    logic [7:0] b; int n;
    load_a(32'hAABB_CCDD); wbyte(4'd4, 8'h11); wbyte(4'd6, 8'h22); wbyte(4'd7, 8'h01);
    repeat (3) @(negedge clk);
    wbyte(4'd14, 8'h5A);
    rd(4'd15, b); chk("R8 clear stops busy", b, 0);
    for (int i = 0; i < 14; i++) begin rd(4'(i), b); chk("R8 clear byte", b, 0); end
    repeat (40) @(negedge clk);
    rd(4'd8, b); chk("R8 aborted result not stored", b, 0);
    wait_idle(n);
  endtask

  task automatic t_write_during_run;
    int n; logic [31:0] q; logic [15:0] rm; logic [7:0] b;
    load_a(32'h0001_0000); wbyte(4'd6, 8'h10); wbyte(4'd7, 8'h00);
    wbyte(4'd0, 8'hFF); wbyte(4'd3, 8'hFF); wbyte(4'd6, 8'h01);
    wait_idle(n);
    rd32(4'd8, q); chk("R9 run isolated quotient", q, 32'h0000_1000);
    rd16(4'd12, rm); chk("R9 run isolated remainder", rm, 0);
    wbyte(4'd8, 8'h77); wbyte(4'd13, 8'h66); wbyte(4'd15, 8'h80);
    rd(4'd8, b); chk("R9 result write ignored", b, 8'h00);
    rd(4'd13, b); chk("R9 remainder write ignored", b, 8'h00);
    rd(4'd15, b); chk("R9 status write ignored", b, 8'h00);
    repeat (10) @(negedge clk);
    rd32(4'd8, q); chk("R10 result stable idle", q, 32'h0000_1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_mul(32'h0000_1234, 16'h5678, "mixed");
    do_mul(32'h0000_FFFF, 16'hFFFF, "max");
    do_mul(32'hABCD_0000, 16'h9999, "zero");
    do_mul(32'h7777_0001, 16'hBEEF, "unit");
    do_div(32'hDEAD_BEEF, 16'h1234, "big");
    do_div(32'hFFFF_FFFF, 16'h0001, "byone");
    do_div(32'h0000_0005, 16'h0007, "small");
    do_div(32'h1234_5678, 16'h0000, "divzero");
    t_status();
    t_restart();
    t_clear();
    t_write_during_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule